// File: doc/BRIEF.md
# Receive Frame Assembler with FCS

The block turns a received payload, announced by a start pulse that carries its byte count, into a complete framed image written byte by byte into a 2048-byte slot buffer. The image opens with a fixed preamble and start delimiter. The payload follows, then zero fill when the payload is shorter than the minimum frame body, and finally a CRC-32 frame check sequence that the block computes itself. One cycle after the last byte is written, the block reports the stored length.

Payload bytes arrive on a valid/ready byte stream. The block asks for bytes only while it is storing payload, so a source may hold a byte valid at any time. When a frame plus its 12 bytes of framing would not fit in the slot, the block writes nothing and reports a length of zero.

Top module: `rx_frame_asm`

## Requirements
- R1: Buffer offsets 0 to 6 receive the byte 0x55 and offset 7 receives 0xD5, written in ascending order right after start.
- R2: Payload bytes are stored in arrival order from offset 8, and each buffer address is written exactly once per frame, in ascending order.
- R3: When the payload is shorter than 60 bytes, zero bytes fill the region from the end of the payload up to offset 67, so that 60 bytes follow the delimiter.
- R4: The four bytes after the padded payload hold the reflected CRC-32 (polynomial 0x04C11DB7, initial value all ones, result inverted) taken over the padded payload only, least significant byte at the lowest address.
- R5: The reported length equals the padded payload length plus 12, so it is never below 72 for an accepted frame.
- R6: A frame whose payload length plus 12 exceeds 2048 causes no buffer write and a reported length of zero. A payload of 2036 bytes is still accepted.
- R7: `done` is high for exactly one cycle. For a stored frame it comes one cycle after the last checksum byte is written. For an oversize frame it comes in the cycle after the one in which start was taken.
- R8: `in_ready` is high only while payload is being stored. A byte offered with `in_valid` while `in_ready` is low is neither written nor counted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a frame when the block is idle |
| in_len | input | 16 | Payload byte count, sampled with start |
| in_valid | input | 1 | Payload byte offered |
| in_data | input | 8 | Payload byte |
| in_ready | output | 1 | Block takes the offered byte this cycle |
| wr_en | output | 1 | Buffer write strobe |
| wr_addr | output | 11 | Buffer byte address |
| wr_data | output | 8 | Buffer byte value |
| done | output | 1 | One-cycle frame completion strobe |
| done_len | output | 12 | Stored length, valid with done; zero for an oversize frame |

## Verification
The bench feeds payloads of 0, 1, 59, 60, 61 and 100 bytes. The short lengths separate the case that needs a single pad byte from the one that needs a full pad. The 60/61 pair shows where padding stops and shifts the checksum position. Some frames have idle gaps in the byte stream and offer junk bytes while the preamble is being written, which exposes any byte taken without a handshake. Lengths of 2036, 2037 and 3000 fix the oversize edge, and every accepted image is compared with a model built from a bit-serial CRC.

// File: rtl/rxfa_pkg.sv
package rxfa_pkg;
  localparam logic [7:0] PRE_BYTE  = 8'h55;
  localparam logic [7:0] SFD_BYTE  = 8'hD5;
  localparam int         HDR_BYTES = 8;
  localparam int         MIN_BODY  = 60;
  localparam int         FCS_BYTES = 4;
  localparam int         FRAMING   = HDR_BYTES + FCS_BYTES;

  typedef enum logic [2:0] {
    S_IDLE, S_PRE, S_PAY, S_PAD, S_FCS, S_DONE
  } asm_state_t;

  // Byte-wide update of the reflected CRC-32 register.
  function automatic logic [31:0] crc32_step(logic [31:0] c, logic [7:0] b);
    logic [31:0] r;
    r = c ^ {24'h0, b};
    for (int i = 0; i < 8; i++)
      r = r[0] ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
    return r;
  endfunction
endpackage

// File: rtl/rxfa_sizer.sv
module rxfa_sizer #(
  parameter int LEN_W     = 16,
  parameter int BUF_BYTES = 2048,
  parameter int TOT_W     = $clog2(BUF_BYTES) + 1
) (
  input  logic [LEN_W-1:0] len,
  output logic             oversize,
  output logic [TOT_W-1:0] total
);
  import rxfa_pkg::*;
  logic [LEN_W:0] len_ext;
  logic [TOT_W-1:0] padded;

  assign len_ext  = {1'b0, len};
  assign oversize = (len_ext + (LEN_W+1)'(FRAMING)) > (LEN_W+1)'(BUF_BYTES);
  assign padded   = (len_ext < (LEN_W+1)'(MIN_BODY)) ? TOT_W'(MIN_BODY)
                                                     : len[TOT_W-1:0];
  assign total    = padded + TOT_W'(FRAMING);
endmodule

// File: rtl/rxfa_crc.sv
module rxfa_crc (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        init,
  input  logic        en,
  input  logic [7:0]  din,
  output logic [31:0] fcs
);
  import rxfa_pkg::*;
  logic [31:0] crc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    crc_q <= '1;
    else if (init) crc_q <= '1;
    else if (en)   crc_q <= crc32_step(crc_q, din);
  end

  assign fcs = ~crc_q;
endmodule

// File: rtl/rxfa_seq.sv
module rxfa_seq #(
  parameter int BUF_BYTES = 2048,
  parameter int ADDR_W    = $clog2(BUF_BYTES),
  parameter int TOT_W     = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [TOT_W-1:0]  len_in,
  input  logic              oversize,
  input  logic [TOT_W-1:0]  total,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  input  logic [31:0]       fcs,
  output logic              in_ready,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              crc_init,
  output logic              crc_en,
  output logic              done,
  output logic [TOT_W-1:0]  done_len
);
  import rxfa_pkg::*;
  localparam logic [TOT_W-1:0] PAD_END = TOT_W'(HDR_BYTES + MIN_BODY);

  asm_state_t        state;
  logic [ADDR_W-1:0] ptr;
  logic [1:0]        fidx;
  logic [TOT_W-1:0]  len_q, len_q_d;
  logic [TOT_W-1:0]  ptr_nx;
  logic              short_pay;
  logic              take;

  assign ptr_nx    = TOT_W'(ptr) + 1'b1;
  assign short_pay = len_q < TOT_W'(MIN_BODY);
  assign take      = (state == S_PAY) && in_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      ptr      <= '0;
      fidx     <= '0;
      len_q    <= '0;
      done_len <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          len_q    <= len_in;
          ptr      <= '0;
          fidx     <= '0;
          done_len <= oversize ? '0 : total;
          state    <= oversize ? S_DONE : S_PRE;
        end
        S_PRE: begin
          ptr <= ptr + 1'b1;
          if (ptr == ADDR_W'(HDR_BYTES - 1))
            state <= (len_q == '0) ? S_PAD : S_PAY;
        end
        S_PAY: if (in_valid) begin
          ptr <= ptr + 1'b1;
          if (ptr_nx == len_q_d) state <= short_pay ? S_PAD : S_FCS;
        end
        S_PAD: begin
          ptr <= ptr + 1'b1;
          if (ptr_nx == PAD_END) state <= S_FCS;
        end
        S_FCS: begin
          ptr  <= ptr + 1'b1;
          fidx <= fidx + 1'b1;
          if (fidx == 2'd3) state <= S_DONE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign len_q_d = len_q + TOT_W'(HDR_BYTES);

  always_comb begin
    case (state)
      S_PRE:   wr_data = (ptr == ADDR_W'(HDR_BYTES - 1)) ? SFD_BYTE : PRE_BYTE;
      S_PAY:   wr_data = in_data;
      S_FCS:   wr_data = fcs[8*fidx +: 8];
      default: wr_data = 8'h00;
    endcase
  end

  assign in_ready = (state == S_PAY);
  assign wr_en    = (state == S_PRE) || (state == S_PAD) || (state == S_FCS) || take;
  assign wr_addr  = ptr;
  assign crc_init = (state == S_IDLE);
  assign crc_en   = take || (state == S_PAD);
  assign done     = (state == S_DONE);

  p_preamble_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr < ADDR_W'(HDR_BYTES)) |->
      wr_data == ((wr_addr == ADDR_W'(HDR_BYTES - 1)) ? SFD_BYTE : PRE_BYTE));

  p_addr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && $past(wr_en)) |-> wr_addr == $past(wr_addr) + 1'b1);

  p_pad_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && TOT_W'(wr_addr) >= len_q_d && TOT_W'(wr_addr) < PAD_END) |->
      wr_data == 8'h00);

  p_ready_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && $past(wr_en) && in_ready) |-> $past(wr_addr) >= ADDR_W'(HDR_BYTES - 1));
endmodule

// File: rtl/rx_frame_asm.sv
module rx_frame_asm #(
  parameter int LEN_W     = 16,
  parameter int BUF_BYTES = 2048,
  parameter int ADDR_W    = $clog2(BUF_BYTES),
  parameter int TOT_W     = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [LEN_W-1:0]  in_len,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  output logic              in_ready,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              done,
  output logic [TOT_W-1:0]  done_len
);
  import rxfa_pkg::*;
  logic             oversize;
  logic [TOT_W-1:0] total;
  logic             crc_init, crc_en;
  logic [31:0]      fcs;

  rxfa_sizer #(.LEN_W(LEN_W), .BUF_BYTES(BUF_BYTES), .TOT_W(TOT_W)) u_sizer (
    .len(in_len), .oversize(oversize), .total(total));

  rxfa_crc u_crc (
    .clk(clk), .rst_n(rst_n), .init(crc_init), .en(crc_en),
    .din(wr_data), .fcs(fcs));

  rxfa_seq #(.BUF_BYTES(BUF_BYTES), .ADDR_W(ADDR_W), .TOT_W(TOT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .len_in(in_len[TOT_W-1:0]),
    .oversize(oversize), .total(total), .in_valid(in_valid), .in_data(in_data),
    .fcs(fcs), .in_ready(in_ready), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .crc_init(crc_init), .crc_en(crc_en),
    .done(done), .done_len(done_len));

  p_min_total_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && done_len != '0) |-> done_len >= TOT_W'(MIN_BODY + FRAMING));

  p_oversize_nowrite_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && done_len == '0) |-> !$past(wr_en));

  p_done_after_fcs_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && done_len != '0) |->
      ($past(wr_en) && (TOT_W'($past(wr_addr)) + 1'b1 == done_len)));

  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: tb/tb_rx_frame_asm.sv
`timescale 1ns/1ps
module tb_rx_frame_asm;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        start = 0;
  logic [15:0] in_len = 0;
  logic        in_valid = 0;
  logic [7:0]  in_data = 0;
  logic        in_ready, wr_en, done;
  logic [10:0] wr_addr;
  logic [7:0]  wr_data;
  logic [11:0] done_len;

  int vectors = 0, fails = 0;
  int cyc = 0;
  logic [7:0] mem [2048];
  logic [7:0] pay [2048];
  int wr_count, last_wr_cyc, start_cyc, done_cyc, done_seen;
  logic [11:0] got_len;

  rx_frame_asm dut (.clk(clk), .rst_n(rst_n), .start(start), .in_len(in_len),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .done(done), .done_len(done_len));

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (wr_en) begin
      mem[wr_addr] = wr_data;
      wr_count++;
      last_wr_cyc = cyc;
    end
    if (start) start_cyc = cyc;
    if (done) begin
      done_seen++;
      done_cyc = cyc;
      got_len = done_len;
    end
  end

  task automatic check(string req, int act, int exp, string what);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_crc(int n);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int i = 0; i < n; i++) begin
      logic [7:0] b = (i < 2048) ? pay[i] : 8'h00;
      for (int k = 0; k < 8; k++) begin
        logic fb = c[0] ^ b[k];
        c = c >> 1;
        if (fb) c = c ^ 32'hEDB88320;
      end
    end
    return ~c;
  endfunction

  task automatic run_frame(int len, int seed, bit gaps, bit junk);
    int body, total, bad;
    logic [31:0] crc;
    for (int i = 0; i < 2048; i++) begin mem[i] = 8'hXX; pay[i] = 8'h00; end
    for (int i = 0; i < len && i < 2048; i++) pay[i] = 8'((i * 7 + seed) ^ (i >> 3));
    wr_count = 0; done_seen = 0; last_wr_cyc = -1;
    @(posedge clk); #1; start = 1; in_len = 16'(len);
    @(posedge clk); #1; start = 0;
    if (len + 12 <= 2048) begin
      for (int i = 0; i < len; i++) begin
        bit acc;
        if (junk) begin
          in_valid = 1; in_data = 8'hEE;
          while (!in_ready) begin @(posedge clk); #1; end
        end
        if (gaps && (i % 5 == 2)) begin in_valid = 0; @(posedge clk); #1; end
        in_valid = 1; in_data = pay[i];
        do begin @(negedge clk); acc = in_ready; @(posedge clk); #1; end while (!acc);
        in_valid = 0;
      end
    end else if (junk) begin
      in_valid = 1; in_data = 8'hEE;
    end
    while (done_seen == 0) begin @(posedge clk); #1; end
    in_valid = 0;
    repeat (3) @(posedge clk); #1;
    check("R7", done_seen, 1, "done pulse count");
    if (len + 12 > 2048) begin
      check("R6", got_len, 0, "oversize length");
      check("R6", wr_count, 0, "oversize writes");
      check("R7", done_cyc, start_cyc + 1, "oversize done cycle");
      return;
    end
    body = (len < 60) ? 60 : len;
    total = body + 12;
    check("R5", got_len, total, "stored length");
    check("R2", wr_count, total, "write count");
    check("R7", done_cyc, last_wr_cyc + 1, "done after last write");
    bad = 0;
    for (int i = 0; i < 7; i++) if (mem[i] !== 8'h55) bad++;
    if (mem[7] !== 8'hD5) bad++;
    check("R1", bad, 0, "preamble mismatches");
    bad = 0;
    for (int i = 0; i < len; i++) if (mem[8 + i] !== pay[i]) bad++;
    check("R2", bad, 0, junk ? "payload mismatches with junk (R8)" : "payload mismatches");
    bad = 0;
    for (int i = len; i < body; i++) if (mem[8 + i] !== 8'h00) bad++;
    check("R3", bad, 0, "pad mismatches");
    crc = ref_crc(body);
    check("R4", {mem[body + 11], mem[body + 10], mem[body + 9], mem[body + 8]}, crc, "fcs");
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R7", done, 0, "reset done");
    check("R2", wr_en, 0, "reset wr_en");
    check("R8", in_ready, 0, "reset in_ready");
  endtask

  task automatic t_empty;      run_frame(0, 1, 0, 0);    endtask
  task automatic t_one;        run_frame(1, 2, 0, 1);    endtask
  task automatic t_short;      run_frame(59, 3, 1, 0);   endtask
  task automatic t_exact_min;  run_frame(60, 4, 0, 1);   endtask
  task automatic t_above_min;  run_frame(61, 5, 1, 0);   endtask
  task automatic t_gapped;     run_frame(100, 6, 1, 1);  endtask
  task automatic t_max_fit;    run_frame(2036, 7, 0, 0); endtask
  task automatic t_over_edge;  run_frame(2037, 8, 0, 1); endtask
  task automatic t_over_far;   run_frame(3000, 9, 0, 0); endtask

  task automatic t_after_oversize;
    run_frame(64, 10, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk); #1;
    rst_n = 1;
    t_reset();
    t_empty();
    t_one();
    t_short();
    t_exact_min();
    t_above_min();
    t_gapped();
    t_max_fit();
    t_over_edge();
    t_over_far();
    t_after_oversize();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule